// File: doc/BRIEF.md
# Encoded Output Clock Divider

This block takes a fast input clock and produces a divided clock on several output channels. Each channel has a true output and an inverted output. A 3-bit code selects the division ratio. The mapping from code to ratio is not monotonic: the lower half of the code space selects ratios 2 to 16, and the upper half selects ratios 1 to 8. Ratio 1 sends the input clock straight through. Every other ratio comes from a counter that toggles a flop once per half period, which gives an exact 50% duty cycle.

A synchronous, active-high master reset holds the divider idle. While it is held, the true outputs are low and the inverted outputs are high. The code may change at any time. A new code only takes effect at the end of a complete output period, on the falling edge of the divided clock. This prevents runt pulses and shortened phases, including when switching into or out of pass-through.

Top module: `clkdiv_enc`

## Requirements
- R1: The division ratio is decoded from `div_code` as follows: 000 divides by 2, 001 by 4, 010 by 8, 011 by 16, 100 passes the clock through (divide by 1), 101 by 2, 110 by 4, and 111 by 8.
- R2: For a ratio of 2H, where H is at least 1, every high phase and every low phase of the output lasts exactly H input clock cycles.
- R3: Once `mr` is sampled high at a rising edge:
  - In divide modes, every `out_p` bit is 0 and every `out_n` bit is 1 from that edge on.
  - In pass-through, this holds from the next falling edge on.
  - It stays so for as long as `mr` stays high.
- R4: Release from reset is timed as follows:
  - With ratio 2H, the first rising output edge happens at the H-th rising edge at which `mr` is sampled low.
  - In pass-through, the first high phase passed is the one that begins at the second such edge.
- R5: In pass-through, the true outputs are high while `clk_in` is high and low while it is low.
- R6: A code change made while a divide ratio is running has no effect until the next falling edge of the divided output. Only the code present at that edge is adopted. Earlier values that were replaced before that edge are ignored.
- R7: Switching between pass-through and a divide ratio produces no runt:
  - Into pass-through: the output stays low after the boundary edge until the next full input high phase.
  - Out of pass-through: the input high phase already in progress completes, and then the output stays low for H cycles.
- R8: All channels carry the same waveform, and each `out_n` bit is the complement of its `out_p` bit.
- R9: The code present while `mr` is high is the one in force immediately after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock to be divided |
| mr | input | 1 | Synchronous active-high master reset |
| div_code | input | 3 | Encoded division ratio select |
| out_p | output | NUM_CH (2) | True divided clock, one bit per channel |
| out_n | output | NUM_CH (2) | Inverted divided clock, one bit per channel |

## Verification
The assertions take for granted that `mr` and `div_code` are synchronous to `clk_in` and settle well away from its rising edge. In particular, they assume that neither input moves inside the half cycle after a rising edge in which the pass-through gate is updated. The bench satisfies this assumption by driving every input change on a falling edge of `clk_in`. It samples divide-mode outputs shortly after each rising edge, and samples pass-through outputs in the middle of both clock phases. Code changes are placed in the middle of an output high phase, so that the boundary rule is exercised against a pending, later period end.

// File: rtl/clkdiv_enc_pkg.sv
`timescale 1ns / 1ps
package clkdiv_enc_pkg;

  // Width of the ratio select code.
  localparam int unsigned CODE_W   = 3;
  // Largest half period, in input cycles (ratio 16 -> 8).
  localparam int unsigned MAX_HALF = 8;
  localparam int unsigned HALF_W   = $clog2(MAX_HALF) + 1;

  // Active divider configuration.
  typedef struct packed {
    logic              byp;   // ratio 1: clock passed through
    logic [HALF_W-1:0] half;  // half period length for even ratios
  } cfg_t;

  // Lower code half: 2 << sel; upper half: 1 << sel, with sel 0 meaning bypass.
  function automatic cfg_t decode_code(input logic [CODE_W-1:0] c);
    cfg_t       r;
    logic [1:0] sel;
    sel = c[1:0];
    r.byp = c[CODE_W-1] && (sel == 2'd0);
    if (!c[CODE_W-1]) begin
      r.half = HALF_W'(1) << sel;
    end else if (sel == 2'd0) begin
      r.half = HALF_W'(1);
    end else begin
      r.half = HALF_W'(1) << (sel - 2'd1);
    end
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_enc_decode.sv
`timescale 1ns / 1ps
module clkdiv_enc_decode
  import clkdiv_enc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output cfg_t              cfg_o
);

  always_comb begin
    cfg_o = decode_code(code_i);
  end

endmodule

// File: rtl/clkdiv_enc_core.sv
`timescale 1ns / 1ps
module clkdiv_enc_core
  import clkdiv_enc_pkg::*;
(
  input  logic              clk,
  input  logic              mr,
  input  cfg_t              dec_cfg_i,
  output cfg_t              act_cfg_o,
  output logic [HALF_W-1:0] cnt_o,
  output logic              div_q_o,
  output logic              div_nxt_o,
  output logic              run_o
);

  cfg_t              cfg_q,  cfg_n;
  logic [HALF_W-1:0] cnt_q,  cnt_n;
  logic              div_q,  div_n;
  logic              run_q,  run_n;
  logic              last_cycle;

  assign last_cycle = (cnt_q == (cfg_q.half - HALF_W'(1)));

  always_comb begin
    cfg_n = cfg_q;
    cnt_n = cnt_q;
    div_n = div_q;
    run_n = run_q;
    if (mr) begin
      // Held idle; keep adopting the code so it is live at release.
      cfg_n = dec_cfg_i;
      cnt_n = '0;
      div_n = 1'b0;
      run_n = 1'b0;
    end else begin
      run_n = 1'b1;
      if (cfg_q.byp) begin
        // Pass-through: every input period is a boundary.
        cfg_n = dec_cfg_i;
        cnt_n = '0;
        div_n = 1'b0;
      end else if (last_cycle) begin
        cnt_n = '0;
        div_n = ~div_q;
        // Falling toggle closes a full period: reload here only.
        if (div_q) begin
          cfg_n = dec_cfg_i;
        end
      end else begin
        cnt_n = cnt_q + HALF_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    cfg_q <= cfg_n;
    cnt_q <= cnt_n;
    div_q <= div_n;
    run_q <= run_n;
  end

  assign act_cfg_o = cfg_q;
  assign cnt_o     = cnt_q;
  assign div_q_o   = div_q;
  assign div_nxt_o = div_n;
  assign run_o     = run_q;

endmodule

// File: rtl/clkdiv_enc_bypass_gate.sv
`timescale 1ns / 1ps
module clkdiv_enc_bypass_gate (
  input  logic clk,
  input  logic byp_i,
  input  logic run_i,
  output logic gate_o
);

  // Updated while the clock is low so the AND gate never chops a high phase.
  logic gate_q;

  always_ff @(negedge clk) begin
    gate_q <= byp_i & run_i;
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/clkdiv_enc_outstage.sv
`timescale 1ns / 1ps
module clkdiv_enc_outstage #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              gate_i,
  input  logic              div_nxt_i,
  output logic [NUM_CH-1:0] out_p,
  output logic [NUM_CH-1:0] out_n
);

  logic [NUM_CH-1:0] ch_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // One flop per channel keeps the fan-out local to each output pair.
    always_ff @(posedge clk) begin
      ch_q[i] <= div_nxt_i;
    end
    // Divider flop is low whenever the gate is open, so OR is glitch free.
    assign out_p[i] = (clk & gate_i) | ch_q[i];
    assign out_n[i] = ~out_p[i];
  end

endmodule

// File: rtl/clkdiv_enc.sv
`timescale 1ns / 1ps
module clkdiv_enc
  import clkdiv_enc_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk_in,
  input  logic              mr,
  input  logic [CODE_W-1:0] div_code,
  output logic [NUM_CH-1:0] out_p,
  output logic [NUM_CH-1:0] out_n
);

  cfg_t              dec_cfg;
  cfg_t              act_cfg;
  logic [HALF_W-1:0] cnt_q;
  logic              div_q;
  logic              div_nxt;
  logic              run_q;
  logic              gate;

  clkdiv_enc_decode u_decode (
    .code_i (div_code),
    .cfg_o  (dec_cfg)
  );

  clkdiv_enc_core u_core (
    .clk       (clk_in),
    .mr        (mr),
    .dec_cfg_i (dec_cfg),
    .act_cfg_o (act_cfg),
    .cnt_o     (cnt_q),
    .div_q_o   (div_q),
    .div_nxt_o (div_nxt),
    .run_o     (run_q)
  );

  clkdiv_enc_bypass_gate u_gate (
    .clk    (clk_in),
    .byp_i  (act_cfg.byp),
    .run_i  (run_q),
    .gate_o (gate)
  );

  clkdiv_enc_outstage #(
    .NUM_CH (NUM_CH)
  ) u_out (
    .clk       (clk_in),
    .gate_i    (gate),
    .div_nxt_i (div_nxt),
    .out_p     (out_p),
    .out_n     (out_n)
  );

endmodule

// File: rtl/clkdiv_enc_chk.sv
`timescale 1ns / 1ps
module clkdiv_enc_chk
  import clkdiv_enc_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              mr,
  input logic [NUM_CH-1:0] out_p,
  input logic [NUM_CH-1:0] out_n,
  input logic              cfg_byp,
  input logic [HALF_W-1:0] cfg_half,
  input logic [HALF_W-1:0] cnt,
  input logic              div_q
);

  localparam int GAP_W = HALF_W + 1;

  logic              prev_div;
  logic              seen;
  logic [GAP_W-1:0]  gap;
  logic [HALF_W-1:0] last_half;

  // Measures the spacing between divider toggles, in input cycles.
  always_ff @(posedge clk) begin
    prev_div <= div_q;
    if (mr || cfg_byp) begin
      seen <= 1'b0;
      gap  <= GAP_W'(1);
    end else if (div_q != prev_div) begin
      seen      <= 1'b1;
      gap       <= GAP_W'(1);
      last_half <= cfg_half;
    end else if (gap != '1) begin
      gap <= gap + GAP_W'(1);
    end
  end

  // R3: reset forces true low and inverted high after the sampling edge.
  p_reset_low_r3: assert property (@(posedge clk)
    mr |=> (out_p == '0 && out_n == {NUM_CH{1'b1}}));

  // R6: configuration holds except at a falling period boundary.
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (mr)
    (!cfg_byp && !(div_q && cnt == cfg_half - HALF_W'(1)))
    |=> ($stable(cfg_half) && $stable(cfg_byp)));

  // R7: divider flop stays idle while the clock is passed through.
  p_byp_idle_r7: assert property (@(posedge clk) disable iff (mr)
    cfg_byp |-> !div_q);

  // R2: every phase lasts exactly the configured half period.
  p_half_phase_r2: assert property (@(posedge clk) disable iff (mr)
    (seen && div_q != prev_div) |-> (gap == GAP_W'(last_half)));

endmodule

bind clkdiv_enc clkdiv_enc_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk      (clk_in),
  .mr       (mr),
  .out_p    (out_p),
  .out_n    (out_n),
  .cfg_byp  (act_cfg.byp),
  .cfg_half (act_cfg.half),
  .cnt      (cnt_q),
  .div_q    (div_q)
);

// File: tb/clkdiv_enc_tb_top.sv
`timescale 1ns / 1ps
module clkdiv_enc_tb_top;

  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           mr  = 1'b1;
  logic [2:0]     code = 3'b000;
  logic [NCH-1:0] out_p;
  logic [NCH-1:0] out_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  clkdiv_enc #(.NUM_CH(NCH)) dut_i (
    .clk_in   (clk),
    .mr       (mr),
    .div_code (code),
    .out_p    (out_p),
    .out_n    (out_n)
  );

  // Half period per R1; 0 stands for pass-through.
  function automatic int exp_half(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b101: return 1;
      3'b110: return 2;
      3'b111: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input logic e, input string req, input int k);
    n_checks++;
    if (out_p !== {NCH{e}} || out_n !== {NCH{~e}}) begin
      n_fail++;
      $display("FAIL %s step %0d: out_p=%b out_n=%b expected out_p=%b out_n=%b",
               req, k, out_p, out_n, {NCH{e}}, {NCH{~e}});
    end
  endtask

  task automatic at_hi();
    @(posedge clk); #2;
  endtask

  task automatic at_lo();
    @(negedge clk); #2;
  endtask

  // Holds reset with code c, then releases on a falling edge.
  task automatic start(input logic [2:0] c);
    @(negedge clk); mr = 1'b1; code = c;
    repeat (3) @(negedge clk);
    mr = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk); mr = 1'b1; code = 3'b011;
    repeat (2) at_hi();
    chk(1'b0, "R3 reset state", 0);
  endtask

  task automatic t_ratios();
    logic [2:0] list [7] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b101, 3'b110, 3'b111};
    for (int i = 0; i < 7; i++) begin
      int h;
      h = exp_half(list[i]);
      start(list[i]);
      for (int k = 1; k <= 8 * h; k++) begin
        at_hi();
        chk(logic'((k / h) & 1), "R1 R2 R4 R8 ratio", k);
      end
    end
  endtask

  task automatic t_bypass();
    start(3'b100);
    for (int k = 1; k <= 8; k++) begin
      at_hi(); chk(k >= 2, "R5 R4 pass-through high", k);
      at_lo(); chk(1'b0, "R5 pass-through low", k);
    end
    mr = 1'b1;
    at_lo();
    at_lo(); chk(1'b0, "R3 bypass reset low phase", 1);
    at_hi(); chk(1'b0, "R3 bypass reset high phase", 2);
    at_lo(); chk(1'b0, "R3 bypass reset low phase", 3);
  endtask

  task automatic t_reset_mid();
    start(3'b010);
    for (int k = 1; k <= 5; k++) begin
      at_hi(); chk(logic'((k / 4) & 1), "R2 before reset", k);
    end
    @(negedge clk); mr = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      at_hi(); chk(1'b0, "R3 reset mid-period", k);
      if (k == 2) begin
        @(negedge clk); code = 3'b011;
      end
    end
    @(negedge clk); mr = 1'b0;
    for (int k = 1; k <= 32; k++) begin
      at_hi(); chk(logic'((k / 8) & 1), "R9 R4 code adopted at release", k);
    end
  endtask

  task automatic t_change();
    start(3'b001);
    for (int k = 1; k <= 33; k++) begin
      logic e;
      at_hi();
      if (k <= 8)       e = logic'((k / 2) & 1);
      else if (k <= 14) e = logic'((k - 8) & 1);
      else              e = logic'(((k - 14) / 8) & 1);
      chk(e, "R6 code change at boundary", k);
      if (k == 6)  begin @(negedge clk); code = 3'b010; end
      if (k == 7)  begin @(negedge clk); code = 3'b000; end
      if (k == 12) begin @(negedge clk); code = 3'b011; end
    end
  endtask

  task automatic t_byp_switch();
    start(3'b000);
    for (int k = 1; k <= 3; k++) begin
      at_hi(); chk(logic'(k & 1), "R2 before switch", k);
    end
    @(negedge clk); code = 3'b100;
    at_hi(); chk(1'b0, "R7 into pass-through boundary", 4);
    at_lo(); chk(1'b0, "R7 into pass-through boundary", 4);
    for (int k = 5; k <= 7; k++) begin
      at_hi(); chk(1'b1, "R7 R5 pass-through high", k);
      if (k == 7) begin
        @(negedge clk); code = 3'b001; #2;
      end else begin
        at_lo();
      end
      chk(1'b0, "R7 R5 pass-through low", k);
    end
    at_hi(); chk(1'b1, "R7 high phase completes", 8);
    at_lo(); chk(1'b0, "R7 low after pass-through", 8);
    for (int k = 9; k <= 16; k++) begin
      at_hi(); chk(logic'(((k - 8) / 2) & 1), "R7 divide after pass-through", k);
    end
  endtask

  initial begin
    t_reset_state();
    t_ratios();
    t_bypass();
    t_reset_mid();
    t_change();
    t_byp_switch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule